// File: doc/BRIEF.md
# MDIO Management Frame Monitor

This block watches a two-wire MII management bus without driving it. A fast system clock samples the management clock and the data line. Each line passes through a short synchroniser. The block then finds rising edges of the management clock. At each such edge it takes one data bit and passes it to a parser state machine. That parser walks the frame fields in order: preamble, start, opcode, PHY address, register address, turnaround and the 16-bit data word. When a frame is complete, the block presents the decoded opcode, both addresses and the data word, marked by a one-cycle `frame_valid` pulse.

A malformed frame sends the parser to an error state. In that state it keeps counting bits until the frame has used 64 bit slots, and then it pulses `error_valid` with a code that names the faulty field. While the parser is in this error state, it measures the average bit spacing of the current frame. If the management clock stops for more than one and a half of those spacings, the error is reported at once with a timeout code and the parser goes back to idle.

Parser states are `S_PRE` (idle, counting preamble ones), `S_START`, `S_OP`, `S_PHY`, `S_REG`, `S_TA`, `S_DATA` and `S_ERR`. Transitions: idle to `S_START` on a 0 as the very first bit, or after the 32nd preamble one. `S_START` to `S_OP` after the bits 0,1. `S_OP` to `S_PHY` after two unequal bits. `S_PHY` to `S_REG` after 5 bits. `S_REG` to `S_TA` after 5 bits. `S_TA` to `S_DATA` after a valid pair. `S_DATA` back to idle after 16 bits, with the frame reported. From any field state, a violation leads to `S_ERR`. `S_ERR` returns to idle on the 64th bit of the frame, or on a stalled clock.

Top module: `mdio_mon`

## Requirements
- R1: A data bit is taken only at a rising edge of `mdc`. Changes on `mdio` while `mdc` is steady have no effect on the decoded frame.
- R2: A frame of 32 ones, start 0,1, opcode, 5 PHY address bits, 5 register address bits, turnaround and 16 data bits, each field sent MSB first, gives one single-cycle `frame_valid` pulse. The pulse carries `phy_addr`, `reg_addr` and `data` equal to the bits sent. `frame_valid` and `error_valid` are never high together.
- R3: If the first bit of a frame is 0, there is no preamble. That bit is taken as the first start bit, and a 32-bit frame is decoded normally.
- R4: A 0 inside the preamble, after the first bit, is an error with `error_code` 1.
- R5: A start field other than 0,1 is an error with `error_code` 2.
- R6: The opcode bits 1,0 give `is_read`=1 and the bits 0,1 give `is_read`=0. Two equal opcode bits are an error with `error_code` 3.
- R7: In the turnaround field, the first bit must be 1 for a write and is not checked for a read. The second bit must be 0 for both. A violation is an error with `error_code` 4.
- R8: After an error, `error_valid` pulses on the 64th bit of the frame, counted from the frame's first bit, and not before. The parser is then idle and decodes the next frame.
- R9: In the error state, if no rising edge arrives for more than 1.5 times the average bit spacing of the frame so far, `error_valid` pulses with `error_code` 5 and the parser resets to idle.
- R10: A stalled `mdc` outside the error state raises no error. When the clock resumes, the frame completes normally.
- R11: After reset, `frame_valid` and `error_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the management clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc | input | 1 | Management clock, asynchronous |
| mdio | input | 1 | Management data, asynchronous |
| frame_valid | output | 1 | One-cycle pulse: a frame was decoded |
| is_read | output | 1 | Opcode of the last frame, 1 = read |
| phy_addr | output | 5 | PHY address of the last frame |
| reg_addr | output | 5 | Register address of the last frame |
| data | output | 16 | Data word of the last frame |
| error_valid | output | 1 | One-cycle pulse: a malformed frame ended |
| error_code | output | 3 | 1 preamble, 2 start, 3 opcode, 4 turnaround, 5 timeout |

## Verification
The assertions assume that `mdc` runs at no more than a quarter of the system clock, so that two detected edges are never adjacent. They also assume that `mdio` is settled before each rising `mdc` edge and stays settled through the synchroniser delay. The bench holds each `mdc` phase for 10 system cycles. It changes `mdio` only while `mdc` is low. In the glitch scenario it changes `mdio` only four or more cycles after the rising edge, which is well past the sampling point. Stalls are made by holding `mdc` low, so the timeout is checked against a steady 20-cycle bit spacing.

// File: rtl/mdio_mon_pkg.sv
package mdio_mon_pkg;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int SHIFT_W    = 2 * ADDR_W + DATA_W;

    typedef enum logic [2:0] {
        S_PRE, S_START, S_OP, S_PHY, S_REG, S_TA, S_DATA, S_ERR
    } state_t;

    typedef enum logic [2:0] {
        E_NONE    = 3'd0,
        E_PRE     = 3'd1,
        E_START   = 3'd2,
        E_OP      = 3'd3,
        E_TA      = 3'd4,
        E_TIMEOUT = 3'd5
    } err_t;
endpackage

// File: rtl/mdio_mon_sync.sv
module mdio_mon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc_i,
    input  logic mdio_i,
    output logic edge_o,
    output logic bit_o
);
    logic [STAGES-1:0] mdc_q;
    logic [STAGES-1:0] mdio_q;
    logic              mdc_prev;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mdc_q[g]  <= 1'b0;
                mdio_q[g] <= 1'b0;
            end else if (g == 0) begin
                mdc_q[g]  <= mdc_i;
                mdio_q[g] <= mdio_i;
            end else begin
                mdc_q[g]  <= mdc_q[(g == 0) ? 0 : g - 1];
                mdio_q[g] <= mdio_q[(g == 0) ? 0 : g - 1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mdc_prev <= 1'b0;
        else        mdc_prev <= mdc_q[STAGES-1];
    end

    assign edge_o = mdc_q[STAGES-1] & ~mdc_prev;
    assign bit_o  = mdio_q[STAGES-1];

    // R1
    edge_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> !edge_o);
endmodule

// File: rtl/mdio_mon_period.sv
module mdio_mon_period #(
    parameter int CNT_W      = 16,
    parameter int IDX_W      = 6,
    parameter int DEF_PERIOD = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    input  logic first_i,
    output logic stall_o
);
    localparam int SPAN_W = CNT_W + IDX_W;
    localparam int CMP_W  = SPAN_W + 3;

    logic [CNT_W-1:0]  idle;
    logic [IDX_W-1:0]  nint;
    logic [SPAN_W-1:0] span;
    logic [SPAN_W:0]   span_sum;
    logic [CMP_W-1:0]  lhs, rhs;

    assign span_sum = {1'b0, span} + (SPAN_W+1)'(idle) + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle <= '0;
            nint <= '0;
            span <= '0;
        end else if (edge_i) begin
            idle <= '0;
            if (first_i) begin
                nint <= '0;
                span <= '0;
            end else begin
                if (nint != '1) nint <= nint + 1'b1;
                span <= span_sum[SPAN_W] ? '1 : span_sum[SPAN_W-1:0];
            end
        end else if (idle != '1) begin
            idle <= idle + 1'b1;
        end
    end

    // idle > 1.5 * span / nint, cross-multiplied to avoid a divider
    always_comb begin
        if (nint == '0) begin
            lhs = CMP_W'(idle) << 1;
            rhs = CMP_W'(DEF_PERIOD) * CMP_W'(3);
        end else begin
            lhs = (CMP_W'(idle) * CMP_W'(nint)) << 1;
            rhs = CMP_W'(span) * CMP_W'(3);
        end
    end

    assign stall_o = lhs > rhs;

    // R9
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_i |=> !stall_o);
endmodule

// File: rtl/mdio_mon.sv
module mdio_mon
    import mdio_mon_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 16,
    parameter int DEF_PERIOD  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdc,
    input  logic              mdio,
    output logic              frame_valid,
    output logic              is_read,
    output logic [ADDR_W-1:0] phy_addr,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] data,
    output logic              error_valid,
    output logic [2:0]        error_code
);
    localparam int CNT_FW = $clog2(DATA_W);

    logic bit_edge, bit_val, stall;

    state_t              state, state_n;
    logic [IDX_W-1:0]    idx, idx_n;
    logic                second, sec_n;
    logic [CNT_FW-1:0]   fcnt, cnt_n;
    logic                op1, op_n;
    logic [SHIFT_W-1:0]  sh, sh_n;
    err_t                ecode, ecode_n;
    logic                done, raise, err_hit;
    err_t                raise_code, err_kind;

    mdio_mon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .mdc_i(mdc), .mdio_i(mdio),
        .edge_o(bit_edge), .bit_o(bit_val)
    );

    mdio_mon_period #(.CNT_W(CNT_W), .IDX_W(IDX_W), .DEF_PERIOD(DEF_PERIOD)) u_period (
        .clk(clk), .rst_n(rst_n), .edge_i(bit_edge),
        .first_i(bit_edge && idx == '0), .stall_o(stall)
    );

    always_comb begin
        state_n    = state;
        idx_n      = idx;
        sec_n      = second;
        cnt_n      = fcnt;
        op_n       = op1;
        sh_n       = sh;
        ecode_n    = ecode;
        done       = 1'b0;
        raise      = 1'b0;
        raise_code = E_NONE;
        err_hit    = 1'b0;
        err_kind   = E_NONE;
        if (bit_edge) begin
            idx_n = idx + 1'b1;
            if (idx == '0 && !bit_val) begin
                state_n = S_START;
                sec_n   = 1'b1;
            end else begin
                unique case (state)
                    S_PRE: begin
                        if (!bit_val) begin
                            err_hit = 1'b1; err_kind = E_PRE;
                        end else if (idx == IDX_W'(PRE_BITS - 1)) begin
                            state_n = S_START; sec_n = 1'b0;
                        end
                    end
                    S_START: begin
                        if (!second) begin
                            if (bit_val) begin err_hit = 1'b1; err_kind = E_START; end
                            else sec_n = 1'b1;
                        end else if (!bit_val) begin
                            err_hit = 1'b1; err_kind = E_START;
                        end else begin
                            state_n = S_OP; sec_n = 1'b0;
                        end
                    end
                    S_OP: begin
                        if (!second) begin
                            op_n = bit_val; sec_n = 1'b1;
                        end else if (bit_val == op1) begin
                            err_hit = 1'b1; err_kind = E_OP;
                        end else begin
                            state_n = S_PHY; sec_n = 1'b0; cnt_n = '0;
                        end
                    end
                    S_PHY, S_REG: begin
                        sh_n  = {sh[SHIFT_W-2:0], bit_val};
                        cnt_n = fcnt + 1'b1;
                        if (fcnt == CNT_FW'(ADDR_W - 1)) begin
                            cnt_n   = '0;
                            state_n = (state == S_PHY) ? S_REG : S_TA;
                            sec_n   = 1'b0;
                        end
                    end
                    S_TA: begin
                        if (!second) begin
                            if (!op1 && !bit_val) begin err_hit = 1'b1; err_kind = E_TA; end
                            else sec_n = 1'b1;
                        end else if (bit_val) begin
                            err_hit = 1'b1; err_kind = E_TA;
                        end else begin
                            state_n = S_DATA; cnt_n = '0;
                        end
                    end
                    S_DATA: begin
                        sh_n  = {sh[SHIFT_W-2:0], bit_val};
                        cnt_n = fcnt + 1'b1;
                        if (fcnt == CNT_FW'(DATA_W - 1)) done = 1'b1;
                    end
                    S_ERR: begin
                        if (idx == IDX_W'(FRAME_BITS - 1)) begin
                            raise = 1'b1; raise_code = ecode;
                        end
                    end
                endcase
            end
        end else if (state == S_ERR && stall) begin
            raise = 1'b1; raise_code = E_TIMEOUT;
        end
        if (err_hit) begin
            state_n = S_ERR;
            ecode_n = err_kind;
        end
        if (done || raise) begin
            state_n = S_PRE;
            idx_n   = '0;
            sec_n   = 1'b0;
            cnt_n   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_PRE;
            idx    <= '0;
            second <= 1'b0;
            fcnt   <= '0;
            op1    <= 1'b0;
            sh     <= '0;
            ecode  <= E_NONE;
        end else begin
            state  <= state_n;
            idx    <= idx_n;
            second <= sec_n;
            fcnt   <= cnt_n;
            op1    <= op_n;
            sh     <= sh_n;
            ecode  <= ecode_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_valid <= 1'b0;
            is_read     <= 1'b0;
            phy_addr    <= '0;
            reg_addr    <= '0;
            data        <= '0;
            error_valid <= 1'b0;
            error_code  <= 3'd0;
        end else begin
            frame_valid <= done;
            error_valid <= raise;
            if (done) begin
                is_read  <= op1;
                phy_addr <= sh_n[SHIFT_W-1 -: ADDR_W];
                reg_addr <= sh_n[DATA_W +: ADDR_W];
                data     <= sh_n[DATA_W-1:0];
            end
            if (raise) error_code <= raise_code;
        end
    end

    // R2
    fv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);
    // R2
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_valid && error_valid));
    // R8
    err_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (error_valid && error_code != 3'd5) |-> $past(bit_edge));
    // R9
    timeout_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (error_valid && error_code == 3'd5) |-> $past(state == S_ERR && !bit_edge));
    // R4
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error_valid |-> (error_code >= 3'd1 && error_code <= 3'd5));
endmodule

// File: tb/mdio_mon_test.sv
module mdio_mon_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mdc = 1'b0;
    logic mdio = 1'b1;
    logic frame_valid, is_read, error_valid;
    logic [4:0] phy_addr, reg_addr;
    logic [15:0] data;
    logic [2:0] error_code;

    int vectors = 0;
    int fails = 0;
    int fv_cnt = 0;
    int ev_cnt = 0;
    logic [2:0] last_code = 3'd0;
    bit glitch = 1'b0;
    int cycles = 0;

    always #5 clk = ~clk;

    mdio_mon uut (
        .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio(mdio),
        .frame_valid(frame_valid), .is_read(is_read),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .data(data),
        .error_valid(error_valid), .error_code(error_code)
    );

    always @(posedge clk) begin
        if (frame_valid) fv_cnt <= fv_cnt + 1;
        if (error_valid) begin
            ev_cnt    <= ev_cnt + 1;
            last_code <= error_code;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 199000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, act=%0d exp=%0d", cycles, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors = vectors + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        mdc  = 1'b0;
        mdio = b;
        wait_clk(10);
        mdc = 1'b1;
        if (glitch) begin
            wait_clk(4);
            mdio = ~b;
            wait_clk(6);
        end else begin
            wait_clk(10);
        end
    endtask

    task automatic send_bits(input logic [63:0] v, input int n, input int stall_at);
        for (int i = 0; i < n; i++) begin
            if (i == stall_at) begin
                mdc = 1'b0;
                wait_clk(300);
            end
            send_bit(v[n-1-i]);
        end
        mdc = 1'b0;
        wait_clk(10);
    endtask

    function automatic logic [63:0] frame(input logic [1:0] op, input logic [4:0] pa,
                                          input logic [4:0] ra, input logic [1:0] ta,
                                          input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, op, pa, ra, ta, d};
    endfunction

    task automatic expect_frame(input string tag, input int fv0, input int ev0,
                                input logic rd, input logic [4:0] pa,
                                input logic [4:0] ra, input logic [15:0] d);
        chk({tag, " frame count"}, fv_cnt, fv0 + 1);
        chk({tag, " no error"}, ev_cnt, ev0);
        chk({tag, " is_read"}, is_read, rd);
        chk({tag, " phy_addr"}, phy_addr, pa);
        chk({tag, " reg_addr"}, reg_addr, ra);
        chk({tag, " data"}, data, d);
    endtask

    // error frame: 64 bits, error pulse only after the 64th
    task automatic err_window(input string tag, input logic [63:0] v, input logic [2:0] code);
        int ev0 = ev_cnt;
        int fv0 = fv_cnt;
        for (int i = 0; i < 64; i++) begin
            send_bit(v[63-i]);
            if (i == 62) chk({tag, " R8 silent before bit 64"}, ev_cnt, ev0);
        end
        chk({tag, " R8 error on bit 64"}, ev_cnt, ev0 + 1);
        chk({tag, " error_code"}, last_code, code);
        chk({tag, " no frame"}, fv_cnt, fv0);
        mdc = 1'b0;
        wait_clk(10);
    endtask

    task automatic t_reset();
        chk("R11 frame_valid after reset", frame_valid, 1'b0);
        chk("R11 error_valid after reset", error_valid, 1'b0);
    endtask

    task automatic t_write();
        int fv0 = fv_cnt; int ev0 = ev_cnt;
        send_bits(frame(2'b01, 5'h13, 5'h0A, 2'b10, 16'hA5C3), 64, -1);
        expect_frame("R2 R6 write", fv0, ev0, 1'b0, 5'h13, 5'h0A, 16'hA5C3);
    endtask

    task automatic t_read();
        int fv0 = fv_cnt; int ev0 = ev_cnt;
        send_bits(frame(2'b10, 5'h01, 5'h1F, 2'b00, 16'h1234), 64, -1);
        expect_frame("R6 R7 read ta first bit unchecked", fv0, ev0, 1'b1, 5'h01, 5'h1F, 16'h1234);
    endtask

    task automatic t_nopre();
        int fv0 = fv_cnt; int ev0 = ev_cnt;
        logic [63:0] f = frame(2'b01, 5'h0C, 5'h03, 2'b10, 16'hFFFE);
        send_bits(f, 32, -1);
        expect_frame("R3 no preamble", fv0, ev0, 1'b0, 5'h0C, 5'h03, 16'hFFFE);
    endtask

    task automatic t_glitch();
        int fv0 = fv_cnt; int ev0 = ev_cnt;
        glitch = 1'b1;
        send_bits(frame(2'b10, 5'h15, 5'h0B, 2'b10, 16'h6C39), 64, -1);
        glitch = 1'b0;
        expect_frame("R1 mdio toggled while mdc high", fv0, ev0, 1'b1, 5'h15, 5'h0B, 16'h6C39);
    endtask

    task automatic t_errors();
        logic [63:0] v;
        v = '1; v[63-10] = 1'b0;
        err_window("R4 preamble zero", v, 3'd1);
        t_write();
        v = '1;
        err_window("R5 start 1,1", v, 3'd2);
        v = '1; v[63] = 1'b0; v[62] = 1'b0;
        err_window("R5 no-preamble start 0,0", v, 3'd2);
        v = frame(2'b11, 5'h00, 5'h00, 2'b10, 16'h0);
        err_window("R6 opcode 1,1", v, 3'd3);
        v = frame(2'b01, 5'h02, 5'h04, 2'b00, 16'h0);
        err_window("R7 write ta first bit 0", v, 3'd4);
        v = frame(2'b10, 5'h02, 5'h04, 2'b11, 16'h0);
        err_window("R7 read ta second bit 1", v, 3'd4);
        t_read();
    endtask

    task automatic t_timeout();
        int ev0 = ev_cnt;
        for (int i = 0; i < 6; i++) send_bit(1'b1);
        send_bit(1'b0);
        mdc = 1'b0;
        wait_clk(5);
        chk("R9 no error right after faulty bit", ev_cnt, ev0);
        wait_clk(60);
        chk("R9 timeout error raised", ev_cnt, ev0 + 1);
        chk("R9 timeout error_code", last_code, 3'd5);
        t_write();
    endtask

    task automatic t_stall();
        int fv0 = fv_cnt; int ev0 = ev_cnt;
        send_bits(frame(2'b01, 5'h07, 5'h11, 2'b10, 16'h8001), 64, 40);
        expect_frame("R10 stall outside error", fv0, ev0, 1'b0, 5'h07, 5'h11, 16'h8001);
    endtask

    initial begin
        wait_clk(5);
        t_reset();
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_write();
        t_read();
        t_nopre();
        t_glitch();
        t_errors();
        t_timeout();
        t_stall();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule